// File: doc/BRIEF.md
# Thread-Isolating Shared Indirect Predictor

This block predicts targets for indirect control transfers on one core that runs two hardware threads. Indirect calls and indirect jumps are looked up in a 64-entry direct-mapped target table that both threads share. Each table entry records which thread trained it. Returns are predicted from a separate 4-deep return stack for each thread. Lookup is combinational. Training happens through an update port and takes effect on the next rising clock edge.

Each thread owns an 8-bit speculation-control register. Bit 0 enables restricted speculation and bit 1 enables thread isolation. If either bit is set in either thread's register, the core enters isolated mode. In that mode a table hit also requires that the entry was trained by the requesting thread, and this applies to entries written before isolation was turned on. When the parameter `IMPL_ISO` is 0, the block accepts writes to bit 1 but does not store them.

Any set bit in positions 7..2 of a register write is a reserved-bit violation. Such a write raises a one-cycle fault pulse for that thread and leaves the register unchanged. Branches of any other kind pass through the block untouched: they never hit and never train it.

Top module: `tip_predictor`

## Requirements
- R1: The branch kind is encoded 00 = other, 01 = indirect call, 10 = indirect jump, 11 = return. A lookup of kind 00 returns hit 0 and target 0. An update of kind 00 changes no table entry and no stack.
- R2: An update of kind 01 or 10 writes the table entry indexed by PC[7:2], with tag PC[31:8], the resolved target and the updating thread as owner. In shared mode, a later lookup of kind 01 or 10 at the same PC from either thread hits with that target. A lookup at the same index with a different tag misses.
- R3: Isolated mode is active while bit 0 or bit 1 is set in either thread's register. In isolated mode, a kind 01/10 lookup hits only when the entry owner equals the requesting thread, and this includes entries trained before the mode was entered. Clearing all those bits restores cross-thread hits.
- R4: A write with bits 7..2 clear stores bit 0 and bit 1 (bit 1 only when `IMPL_ISO` is 1). The register reads back the stored value on the cycle after the write.
- R5: A write with any of bits 7..2 set leaves that thread's register unchanged. It raises that thread's fault bit for exactly the one cycle after the write.
- R6: With `IMPL_ISO` = 0, bit 1 of a write is dropped without a fault, bit 1 always reads 0, bit 0 is still written, and setting bit 1 does not block cross-thread hits.
- R7: A kind 01 update pushes PC+4 onto the updating thread's return stack. A kind 11 lookup hits with that thread's top entry and misses on an empty stack. A kind 11 update pops that stack. The stacks are per thread in every mode.
- R8: A push onto a full 4-deep stack discards the oldest entry, so the following pops return the four newest return addresses, newest first.
- R9: A synchronous reset clears every table valid bit, both stacks, both registers and both fault bits.
- R10: Training a PC whose index matches an existing entry but whose tag differs replaces that entry, so the old PC then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_tid | input | 1 | Thread making the lookup |
| lk_pc | input | 32 | Branch address for lookup |
| lk_kind | input | 2 | Branch kind for lookup |
| lk_hit | output | 1 | Prediction available |
| lk_target | output | 32 | Predicted target (0 on a miss) |
| up_valid | input | 1 | Training request valid |
| up_tid | input | 1 | Thread that resolved the branch |
| up_pc | input | 32 | Resolved branch address |
| up_kind | input | 2 | Resolved branch kind |
| up_target | input | 32 | Resolved target |
| cr_we | input | 2 | Register write strobe, one bit per thread |
| cr_wdata | input | 16 | Write data, thread t in bits [8t+7:8t] |
| cr_rdata | output | 16 | Register contents, thread t in bits [8t+7:8t] |
| cr_fault | output | 2 | Reserved-bit fault pulse, one bit per thread |

## Verification
The bench checks that stale entries are filtered. A design that compared owners only when writing the table would still hand thread 0 a target that thread 1 trained before isolation began. It also sets restricted speculation on the other thread only, which catches a design that tests just the caller's own isolation bit. Further cases are a reserved-bit write and a build without the isolation feature: a wrong design would either change the register or raise a spurious fault. The bench overflows the return stack, which shows whether the design drops the oldest entry or corrupts the newest. It also aliases two PCs onto one table index, which shows whether the design checks the tag.

// File: rtl/tip_pkg.sv
package tip_pkg;
    typedef enum logic [1:0] {
        BK_OTHER = 2'd0,
        BK_ICALL = 2'd1,
        BK_IJMP  = 2'd2,
        BK_RET   = 2'd3
    } br_kind_e;

    typedef enum logic {
        CM_SHARED   = 1'b0,
        CM_ISOLATED = 1'b1
    } ctl_mode_e;
endpackage

// File: rtl/tip_spec_ctrl.sv
module tip_spec_ctrl
    import tip_pkg::*;
#(
    parameter int NTHR     = 2,
    parameter int CW       = 8,
    parameter bit IMPL_ISO = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NTHR-1:0]      we,
    input  logic [NTHR*CW-1:0]   wdata,
    output logic [NTHR*CW-1:0]   rdata,
    output logic [NTHR-1:0]      fault,
    output logic                 iso_active
);
    logic [CW-1:0]   reg_q   [NTHR];
    logic [CW-1:0]   reg_nxt [NTHR];
    logic [NTHR-1:0] resv_hit;
    logic            any_nxt;
    ctl_mode_e       mode_q, mode_d;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        assign resv_hit[t] = |wdata[t*CW+2 +: CW-2];

        always_comb begin
            reg_nxt[t] = reg_q[t];
            if (we[t] && !resv_hit[t]) begin
                reg_nxt[t]    = '0;
                reg_nxt[t][0] = wdata[t*CW];
                reg_nxt[t][1] = wdata[t*CW+1] & IMPL_ISO;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                reg_q[t] <= '0;
                fault[t] <= 1'b0;
            end else begin
                reg_q[t] <= reg_nxt[t];
                fault[t] <= we[t] & resv_hit[t];
            end
        end

        assign rdata[t*CW +: CW] = reg_q[t];
    end

    always_comb begin
        any_nxt = 1'b0;
        for (int t = 0; t < NTHR; t++) begin
            any_nxt = any_nxt | reg_nxt[t][0] | reg_nxt[t][1];
        end
    end

    // Mode state register
    always_ff @(posedge clk) begin
        if (rst) mode_q <= CM_SHARED;
        else     mode_q <= mode_d;
    end

    // Transitions: SHARED->ISOLATED when a control bit becomes set, back when all clear
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            CM_SHARED:   if (any_nxt)  mode_d = CM_ISOLATED;
            CM_ISOLATED: if (!any_nxt) mode_d = CM_SHARED;
            default:     mode_d = CM_SHARED;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (mode_q)
            CM_ISOLATED: iso_active = 1'b1;
            default:     iso_active = 1'b0;
        endcase
    end
endmodule

// File: rtl/tip_btb.sv
module tip_btb #(
    parameter int ENTRIES = 64,
    parameter int AW      = 32,
    parameter int TID_W   = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    rd_pc,
    output logic             rd_match,
    output logic [AW-1:0]    rd_target,
    output logic [TID_W-1:0] rd_owner,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_pc,
    input  logic [AW-1:0]    wr_target,
    input  logic [TID_W-1:0] wr_owner
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = AW - IDX_W - 2;

    logic [ENTRIES-1:0] vld;
    logic [TAG_W-1:0]   tag_m [ENTRIES];
    logic [AW-1:0]      tgt_m [ENTRIES];
    logic [TID_W-1:0]   own_m [ENTRIES];

    logic [IDX_W-1:0] rd_idx, wr_idx;
    assign rd_idx = rd_pc[IDX_W+1:2];
    assign wr_idx = wr_pc[IDX_W+1:2];

    always_ff @(posedge clk) begin
        if (rst)        vld         <= '0;
        else if (wr_en) vld[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_m[wr_idx] <= wr_pc[AW-1:IDX_W+2];
            tgt_m[wr_idx] <= wr_target;
            own_m[wr_idx] <= wr_owner;
        end
    end

    assign rd_match  = vld[rd_idx] && (tag_m[rd_idx] == rd_pc[AW-1:IDX_W+2]);
    assign rd_target = tgt_m[rd_idx];
    assign rd_owner  = own_m[rd_idx];
endmodule

// File: rtl/tip_ras.sv
module tip_ras #(
    parameter int DEPTH = 4,
    parameter int AW    = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_val,
    output logic [AW-1:0] top_val,
    output logic          nonempty
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0]    stk [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic             full;
    logic [CNT_W-1:0] cnt_m1;

    assign full     = (cnt == CNT_W'(DEPTH));
    assign nonempty = (cnt != '0);
    assign cnt_m1   = cnt - 1'b1;

    always_ff @(posedge clk) begin
        if (rst)                       cnt <= '0;
        else if (push && !full)        cnt <= cnt + 1'b1;
        else if (!push && pop && nonempty) cnt <= cnt_m1;
    end

    always_ff @(posedge clk) begin
        if (push) begin
            if (full) begin
                for (int i = 0; i < DEPTH - 1; i++) stk[i] <= stk[i+1];
                stk[DEPTH-1] <= push_val;
            end else begin
                stk[cnt[IDX_W-1:0]] <= push_val;
            end
        end
    end

    assign top_val = stk[cnt_m1[IDX_W-1:0]];
endmodule

// File: rtl/tip_predictor.sv
module tip_predictor
    import tip_pkg::*;
#(
    parameter int NTHR        = 2,
    parameter int AW          = 32,
    parameter int CW          = 8,
    parameter int BTB_ENTRIES = 64,
    parameter int RAS_DEPTH   = 4,
    parameter bit IMPL_ISO    = 1'b1,
    localparam int TID_W      = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [TID_W-1:0]     lk_tid,
    input  logic [AW-1:0]        lk_pc,
    input  logic [1:0]           lk_kind,
    output logic                 lk_hit,
    output logic [AW-1:0]        lk_target,
    input  logic                 up_valid,
    input  logic [TID_W-1:0]     up_tid,
    input  logic [AW-1:0]        up_pc,
    input  logic [1:0]           up_kind,
    input  logic [AW-1:0]        up_target,
    input  logic [NTHR-1:0]      cr_we,
    input  logic [NTHR*CW-1:0]   cr_wdata,
    output logic [NTHR*CW-1:0]   cr_rdata,
    output logic [NTHR-1:0]      cr_fault
);
    logic             iso_active;
    logic             btb_match;
    logic [AW-1:0]    btb_tgt;
    logic [TID_W-1:0] lk_owner;
    logic             btb_we;
    br_kind_e         lk_k, up_k;

    assign lk_k   = br_kind_e'(lk_kind);
    assign up_k   = br_kind_e'(up_kind);
    assign btb_we = up_valid && (up_k == BK_ICALL || up_k == BK_IJMP);

    tip_spec_ctrl #(.NTHR(NTHR), .CW(CW), .IMPL_ISO(IMPL_ISO)) u_ctrl (
        .clk(clk), .rst(rst), .we(cr_we), .wdata(cr_wdata),
        .rdata(cr_rdata), .fault(cr_fault), .iso_active(iso_active)
    );

    tip_btb #(.ENTRIES(BTB_ENTRIES), .AW(AW), .TID_W(TID_W)) u_btb (
        .clk(clk), .rst(rst), .rd_pc(lk_pc), .rd_match(btb_match),
        .rd_target(btb_tgt), .rd_owner(lk_owner), .wr_en(btb_we),
        .wr_pc(up_pc), .wr_target(up_target), .wr_owner(up_tid)
    );

    logic [NTHR-1:0] ras_push, ras_pop, ras_ne;
    logic [AW-1:0]   ras_top [NTHR];

    for (genvar t = 0; t < NTHR; t++) begin : g_ras
        assign ras_push[t] = up_valid && (up_tid == TID_W'(t)) && (up_k == BK_ICALL);
        assign ras_pop[t]  = up_valid && (up_tid == TID_W'(t)) && (up_k == BK_RET);
        tip_ras #(.DEPTH(RAS_DEPTH), .AW(AW)) u_ras (
            .clk(clk), .rst(rst), .push(ras_push[t]), .pop(ras_pop[t]),
            .push_val(up_pc + AW'(4)), .top_val(ras_top[t]), .nonempty(ras_ne[t])
        );
    end

    always_comb begin
        lk_hit    = 1'b0;
        lk_target = '0;
        unique case (lk_k)
            BK_ICALL, BK_IJMP: begin
                if (btb_match && (!iso_active || lk_owner == lk_tid)) begin
                    lk_hit    = 1'b1;
                    lk_target = btb_tgt;
                end
            end
            BK_RET: begin
                if (ras_ne[lk_tid]) begin
                    lk_hit    = 1'b1;
                    lk_target = ras_top[lk_tid];
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tip_predictor_chk.sv
module tip_predictor_chk #(
    parameter int NTHR     = 2,
    parameter int AW       = 32,
    parameter int CW       = 8,
    parameter int TID_W    = 1,
    parameter bit IMPL_ISO = 1'b1
) (
    input logic               clk,
    input logic               rst,
    input logic [TID_W-1:0]   lk_tid,
    input logic [1:0]         lk_kind,
    input logic               lk_hit,
    input logic [AW-1:0]      lk_target,
    input logic [NTHR-1:0]    cr_we,
    input logic [NTHR*CW-1:0] cr_wdata,
    input logic [NTHR*CW-1:0] cr_rdata,
    input logic [NTHR-1:0]    cr_fault,
    input logic               iso_active,
    input logic [TID_W-1:0]   lk_owner
);
    AST_OTHER_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        (lk_kind == 2'd0) |-> (!lk_hit && lk_target == '0)) else $error("other kind hit"); // R1

    AST_ISO_OWNER: assert property (@(posedge clk) disable iff (rst)
        (iso_active && lk_hit && (lk_kind == 2'd1 || lk_kind == 2'd2)) |-> (lk_owner == lk_tid))
        else $error("cross-thread hit while isolated"); // R3

    for (genvar t = 0; t < NTHR; t++) begin : g_chk
        AST_WRITE_BIT0: assert property (@(posedge clk) disable iff (rst)
            (cr_we[t] && cr_wdata[t*CW+2 +: CW-2] == '0) |=> (cr_rdata[t*CW] == $past(cr_wdata[t*CW])))
            else $error("bit0 not stored"); // R4

        AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (rst)
            cr_fault[t] |-> ($past(cr_we[t]) && $past(cr_wdata[t*CW+2 +: CW-2]) != '0))
            else $error("fault without reserved write"); // R5

        AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
            cr_fault[t] |-> $stable(cr_rdata[t*CW +: CW]))
            else $error("faulting write changed register"); // R5

        AST_NO_ISO_BIT: assert property (@(posedge clk) disable iff (rst)
            (!IMPL_ISO) |-> !cr_rdata[t*CW+1])
            else $error("isolation bit stored when absent"); // R6
    end
endmodule

bind tip_predictor tip_predictor_chk #(
    .NTHR(NTHR), .AW(AW), .CW(CW), .TID_W(TID_W), .IMPL_ISO(IMPL_ISO)
) u_chk (
    .clk(clk), .rst(rst), .lk_tid(lk_tid), .lk_kind(lk_kind), .lk_hit(lk_hit),
    .lk_target(lk_target), .cr_we(cr_we), .cr_wdata(cr_wdata), .cr_rdata(cr_rdata),
    .cr_fault(cr_fault), .iso_active(iso_active), .lk_owner(lk_owner)
);

// File: tb/tip_predictor_bench.sv
module tip_predictor_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_tid = 1'b0;
    logic [31:0] lk_pc = '0;
    logic [1:0]  lk_kind = '0;
    logic        up_valid = 1'b0;
    logic        up_tid = 1'b0;
    logic [31:0] up_pc = '0;
    logic [1:0]  up_kind = '0;
    logic [31:0] up_target = '0;
    logic [1:0]  cr_we = '0;
    logic [15:0] cr_wdata = '0;

    logic        a_hit, b_hit;
    logic [31:0] a_tgt, b_tgt;
    logic [15:0] a_rd, b_rd;
    logic [1:0]  a_flt, b_flt;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    tip_predictor u_tip_predictor (
        .clk(clk), .rst(rst), .lk_tid(lk_tid), .lk_pc(lk_pc), .lk_kind(lk_kind),
        .lk_hit(a_hit), .lk_target(a_tgt), .up_valid(up_valid), .up_tid(up_tid),
        .up_pc(up_pc), .up_kind(up_kind), .up_target(up_target), .cr_we(cr_we),
        .cr_wdata(cr_wdata), .cr_rdata(a_rd), .cr_fault(a_flt)
    );

    tip_predictor #(.IMPL_ISO(1'b0)) u_tip_predictor_noiso (
        .clk(clk), .rst(rst), .lk_tid(lk_tid), .lk_pc(lk_pc), .lk_kind(lk_kind),
        .lk_hit(b_hit), .lk_target(b_tgt), .up_valid(up_valid), .up_tid(up_tid),
        .up_pc(up_pc), .up_kind(up_kind), .up_target(up_target), .cr_we(cr_we),
        .cr_wdata(cr_wdata), .cr_rdata(b_rd), .cr_fault(b_flt)
    );

    // {tid, kind, pc, target}
    localparam logic [66:0] VEC [6] = '{
        {1'b0, 2'd1, 32'h0000_1000, 32'h0000_8000},
        {1'b1, 2'd2, 32'h0000_2104, 32'h1234_5678},
        {1'b0, 2'd2, 32'h0000_30F8, 32'hCAFE_0000},
        {1'b1, 2'd1, 32'hABCD_00FC, 32'h0000_0040},
        {1'b0, 2'd2, 32'h4000_0010, 32'h0000_0ACE},
        {1'b1, 2'd2, 32'h0000_2208, 32'h7777_0000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic train(input logic tid, input logic [1:0] kind, input logic [31:0] pc, input logic [31:0] tgt);
        @(negedge clk);
        up_valid = 1'b1; up_tid = tid; up_kind = kind; up_pc = pc; up_target = tgt;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic look(input logic tid, input logic [1:0] kind, input logic [31:0] pc,
                        input logic eh, input logic [31:0] et, input string tag);
        @(negedge clk);
        lk_tid = tid; lk_kind = kind; lk_pc = pc;
        #1;
        check({tag, " hit"}, {31'd0, a_hit}, {31'd0, eh});
        check({tag, " target"}, a_tgt, eh ? et : 32'd0);
    endtask

    task automatic wr(input int tid, input logic [7:0] d);
        @(negedge clk);
        cr_we = '0; cr_we[tid] = 1'b1; cr_wdata[tid*8 +: 8] = d;
        @(negedge clk);
        cr_we = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: state after reset
        check("R9 rdata a", {16'd0, a_rd}, 32'd0);
        check("R9 fault a", {30'd0, a_flt}, 32'd0);
        rst = 1'b0;
        look(1'b0, 2'd1, 32'h0000_1000, 1'b0, 32'd0, "R9 empty table");
        look(1'b0, 2'd3, 32'h0, 1'b0, 32'd0, "R9 empty stack");

        // R2: table vectors, looked up from the other thread in shared mode
        for (int i = 0; i < 6; i++) train(VEC[i][66], VEC[i][65:64], VEC[i][63:32], VEC[i][31:0]);
        for (int i = 0; i < 6; i++)
            look(~VEC[i][66], VEC[i][65:64], VEC[i][63:32], 1'b1, VEC[i][31:0], "R2 shared hit");

        // R7: per-thread return stacks
        look(1'b0, 2'd3, 32'h0, 1'b1, 32'h0000_1004, "R7 t0 top");
        look(1'b1, 2'd3, 32'h0, 1'b1, 32'hABCD_0100, "R7 t1 top");
        train(1'b0, 2'd3, 32'h0000_9000, 32'h0000_1004);
        look(1'b0, 2'd3, 32'h0, 1'b0, 32'd0, "R7 t0 empty after pop");
        look(1'b1, 2'd3, 32'h0, 1'b1, 32'hABCD_0100, "R7 t1 untouched");
        train(1'b1, 2'd3, 32'h0000_9100, 32'hABCD_0100);

        // R1: other kind
        look(1'b0, 2'd0, 32'h0000_1000, 1'b0, 32'd0, "R1 other lookup");
        train(1'b0, 2'd0, 32'h0000_1000, 32'h0000_DEAD);
        look(1'b0, 2'd1, 32'h0000_1000, 1'b1, 32'h0000_8000, "R1 other no train");
        look(1'b0, 2'd3, 32'h0, 1'b0, 32'd0, "R1 other no push");

        // R2 tag mismatch, R10 replacement
        look(1'b0, 2'd2, 32'h0001_1000, 1'b0, 32'd0, "R2 tag mismatch");
        train(1'b0, 2'd2, 32'h0001_1000, 32'h0000_5555);
        look(1'b0, 2'd2, 32'h0001_1000, 1'b1, 32'h0000_5555, "R10 new entry");
        look(1'b1, 2'd1, 32'h0000_1000, 1'b0, 32'd0, "R10 old evicted");

        // R3/R4: isolation via bit 1 on thread 0; entry at 0x2104 was trained by thread 1 earlier
        wr(0, 8'h02);
        check("R4 rdata t0", {24'd0, a_rd[7:0]}, 32'h02);
        check("R4 no fault", {30'd0, a_flt}, 32'd0);
        check("R6 bit1 dropped", {24'd0, b_rd[7:0]}, 32'h00);
        check("R6 no fault", {30'd0, b_flt}, 32'd0);
        look(1'b0, 2'd2, 32'h0000_2104, 1'b0, 32'd0, "R3 stale cross entry");
        check("R6 still shared", {31'd0, b_hit}, 32'd1);
        look(1'b1, 2'd2, 32'h0000_2104, 1'b1, 32'h1234_5678, "R3 owner hit");
        wr(0, 8'h00);
        look(1'b0, 2'd2, 32'h0000_2104, 1'b1, 32'h1234_5678, "R3 sharing restored");

        // R3: bit 0 on the other thread also isolates
        wr(1, 8'h01);
        check("R4 rdata t1", {24'd0, a_rd[15:8]}, 32'h01);
        check("R6 bit0 written", {24'd0, b_rd[15:8]}, 32'h01);
        look(1'b0, 2'd2, 32'h0000_2104, 1'b0, 32'd0, "R3 other thread bit0");

        // R7: stacks private regardless of isolation
        train(1'b1, 2'd1, 32'h0000_0600, 32'h0000_9000);
        look(1'b1, 2'd3, 32'h0, 1'b1, 32'h0000_0604, "R7 t1 push in iso");
        look(1'b0, 2'd3, 32'h0, 1'b0, 32'd0, "R7 t0 not shared");
        look(1'b0, 2'd1, 32'h0000_0600, 1'b0, 32'd0, "R3 new cross entry");
        train(1'b1, 2'd3, 32'h0000_9200, 32'h0000_0604);

        // R5: reserved bit write
        wr(1, 8'h03);
        check("R4 rdata t1 both", {24'd0, a_rd[15:8]}, 32'h03);
        check("R6 b bit1 dropped", {24'd0, b_rd[15:8]}, 32'h01);
        wr(1, 8'h84);
        check("R5 fault pulse", {30'd0, a_flt}, 32'h2);
        check("R5 reg unchanged", {24'd0, a_rd[15:8]}, 32'h03);
        check("R5 b fault pulse", {30'd0, b_flt}, 32'h2);
        @(negedge clk);
        check("R5 pulse ends", {30'd0, a_flt}, 32'd0);
        wr(1, 8'h00);

        // R8: overflow of thread-0 stack
        for (int i = 1; i <= 5; i++) train(1'b0, 2'd1, 32'(i * 256), 32'h0000_7000);
        for (int i = 5; i >= 2; i--) begin
            look(1'b0, 2'd3, 32'h0, 1'b1, 32'(i * 256 + 4), "R8 pop order");
            train(1'b0, 2'd3, 32'h0000_9300, 32'h0);
        end
        look(1'b0, 2'd3, 32'h0, 1'b0, 32'd0, "R8 oldest dropped");

        // R9: reset mid-run
        train(1'b0, 2'd1, 32'h0000_0100, 32'h0000_1111);
        wr(0, 8'h03);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        check("R9 regs cleared", {16'd0, a_rd}, 32'd0);
        look(1'b0, 2'd1, 32'h0000_0100, 1'b0, 32'd0, "R9 table cleared");
        look(1'b0, 2'd3, 32'h0, 1'b0, 32'd0, "R9 stack cleared");

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule